// File: doc/BRIEF.md
# Data-Strobe Character Transmitter

This block turns link-level requests into a continuous serial character stream on a Data-Strobe line pair. A client offers data bytes and packet terminators on one request port, flow-control tokens on a second and time codes on a third. Each port completes a transfer when its valid and ready signals are both high at a clock edge. The block frames each request as a character, carrying a parity bit and a data/control flag. It then shifts the character out one bit per clock. When no request is waiting, it fills the line with NULL characters so that the far end keeps seeing activity.

Parity forms a chain across characters. The parity bit of each character is chosen so that the bits it covers have odd parity. Those bits are the payload of the character before it, the parity bit itself and the current flag. Deasserting the enable holds both lines low and clears the chain, so the next enabled period restarts exactly as after reset. Link start-up sequencing, credit counting and the electrical drivers are handled outside the block.

Top module: `ds_char_tx`

## Requirements
- R1: A data character is 10 bits on the line: the parity bit, then a flag of 0, then the 8 data bits with the least significant bit first. A data request is `req_kind` = 00, and its byte is `req_byte`.
- R2: A control character is 4 bits: the parity bit, then a flag of 1, then a 2-bit code with its least significant bit first. The codes are FCT = 00, EOP = 01, EEP = 10 and ESC = 11. `req_kind` = 01 sends EOP, and 10 or 11 sends EEP.
- R3: When no request is pending at the start of a character, the block sends NULL, which is ESC followed by FCT. After reset, an enabled idle line therefore starts with the bits 0,1,1,1,0,1,0,0.
- R4: A time code is ESC followed by a data character that carries `tc_value`, 14 bits in all.
- R5: The parity bit, together with the previous character's payload bits (code or data) and the current flag, gives an odd count of ones. After reset, or after a disabled period, the first character treats the previous payload as empty.
- R6: Each enabled clock places one new bit on `dout`. Exactly one of `dout` and `sout` changes at that edge, and the characters follow one another without gaps.
- R7: While `tx_en` is low, both lines go to 0 at the next edge, every ready output stays low, and the parity chain restarts.
- R8: At each character start, a time code wins over an FCT, an FCT wins over the request port, and NULL is sent only when nothing is valid.
- R9: A ready output is high only in the first cycle of the character that serves it, and only one ready is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_en | input | 1 | Transmit enable; low holds the lines at 0 |
| tc_valid | input | 1 | Time code request |
| tc_value | input | 8 | Time value carried by the time code |
| tc_ready | output | 1 | Time code accepted this cycle |
| fct_valid | input | 1 | Flow-control token request |
| fct_ready | output | 1 | Token accepted this cycle |
| req_valid | input | 1 | Data or terminator request |
| req_kind | input | 2 | 00 data, 01 EOP, 10/11 EEP |
| req_byte | input | 8 | Data byte for a data request |
| req_ready | output | 1 | Request accepted this cycle |
| dout | output | 1 | Data line |
| sout | output | 1 | Strobe line |

## Verification
The assertions assume that reset is asserted at time zero. They also assume that each client keeps its valid, value and kind inputs steady from the moment valid rises until the matching ready has been seen at an edge. The bench follows this rule: it changes request inputs only at falling edges, holds them until it observes its own ready, and then drops valid at the next falling edge. It also changes `tx_en` only at falling edges, so each enabled edge shifts exactly one bit. The bench decodes the line pair back into characters and checks parity and the strobe rule on every bit. It compares the decoded sequence against its table of expected characters and against directed priority and disable cases.

// File: rtl/ds_tx_pkg.sv
package ds_tx_pkg;
  localparam int BYTE_W = 8;
  localparam int CODE_W = 2;
  localparam int ESC_W  = 2 + CODE_W;

  typedef enum logic [CODE_W-1:0] {
    CODE_FCT = 2'b00,
    CODE_EOP = 2'b01,
    CODE_EEP = 2'b10,
    CODE_ESC = 2'b11
  } ctrl_code_e;

  typedef struct packed {
    logic              esc_prefix;
    logic              is_data;
    logic [BYTE_W-1:0] body;
  } char_sel_t;
endpackage

// File: rtl/ds_char_select.sv
module ds_char_select
  import ds_tx_pkg::*;
(
  input  logic              load,
  input  logic              tc_valid,
  input  logic [BYTE_W-1:0] tc_value,
  input  logic              fct_valid,
  input  logic              req_valid,
  input  logic [1:0]        req_kind,
  input  logic [BYTE_W-1:0] req_byte,
  output char_sel_t         sel,
  output logic              tc_ready,
  output logic              fct_ready,
  output logic              req_ready
);
  localparam int PAD_W = BYTE_W - CODE_W;

  always_comb begin
    tc_ready       = 1'b0;
    fct_ready      = 1'b0;
    req_ready      = 1'b0;
    sel.esc_prefix = 1'b1;
    sel.is_data    = 1'b0;
    sel.body       = {{PAD_W{1'b0}}, CODE_FCT};
    if (tc_valid) begin
      sel.esc_prefix = 1'b1;
      sel.is_data    = 1'b1;
      sel.body       = tc_value;
      tc_ready       = load;
    end else if (fct_valid) begin
      sel.esc_prefix = 1'b0;
      sel.body       = {{PAD_W{1'b0}}, CODE_FCT};
      fct_ready      = load;
    end else if (req_valid) begin
      sel.esc_prefix = 1'b0;
      if (req_kind == 2'b00) begin
        sel.is_data = 1'b1;
        sel.body    = req_byte;
      end else if (req_kind == 2'b01) begin
        sel.body = {{PAD_W{1'b0}}, CODE_EOP};
      end else begin
        sel.body = {{PAD_W{1'b0}}, CODE_EEP};
      end
      req_ready = load;
    end
  end
endmodule

// File: rtl/ds_char_serializer.sv
module ds_char_serializer
  import ds_tx_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      tx_en,
  input  char_sel_t sel,
  output logic      load,
  output logic      bit_out
);
  localparam int MAIN_W = 2 + BYTE_W;
  localparam int MAX_W  = MAIN_W + ESC_W;
  localparam int CNT_W  = $clog2(MAX_W + 1);
  localparam int PAD_W  = BYTE_W - CODE_W;

  logic [MAX_W-1:0]  sh_q, sh_d;
  logic [CNT_W-1:0]  rem_q, rem_d;
  logic              prev_q, prev_d;

  logic              flag, pm, pe, pay_x;
  logic [MAIN_W-1:0] main_v;
  logic [CNT_W-1:0]  main_len, char_len;
  logic [MAX_W-1:0]  char_v;

  // character framing
  always_comb begin
    flag = ~sel.is_data;
    pe   = prev_q;
    pm   = sel.esc_prefix ? ~flag : ~(prev_q ^ flag);
    if (sel.is_data) begin
      main_v   = {sel.body, 1'b0, pm};
      main_len = CNT_W'(MAIN_W);
      pay_x    = ^sel.body;
    end else begin
      main_v   = {{PAD_W{1'b0}}, sel.body[CODE_W-1:0], 1'b1, pm};
      main_len = CNT_W'(ESC_W);
      pay_x    = ^sel.body[CODE_W-1:0];
    end
    if (sel.esc_prefix) begin
      char_v   = {main_v, CODE_ESC, 1'b1, pe};
      char_len = main_len + CNT_W'(ESC_W);
    end else begin
      char_v   = {{ESC_W{1'b0}}, main_v};
      char_len = main_len;
    end
  end

  // next state
  always_comb begin
    load    = tx_en && (rem_q == '0);
    sh_d    = sh_q;
    rem_d   = rem_q;
    prev_d  = prev_q;
    bit_out = 1'b0;
    if (!tx_en) begin
      sh_d   = '0;
      rem_d  = '0;
      prev_d = 1'b0;
    end else if (load) begin
      bit_out = char_v[0];
      sh_d    = char_v >> 1;
      rem_d   = char_len - CNT_W'(1);
      prev_d  = pay_x;
    end else begin
      bit_out = sh_q[0];
      sh_d    = sh_q >> 1;
      rem_d   = rem_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      rem_q  <= '0;
      prev_q <= 1'b0;
    end else begin
      sh_q   <= sh_d;
      rem_q  <= rem_d;
      prev_q <= prev_d;
    end
  end

  assert_rem_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rem_q < CNT_W'(MAX_W));
  assert_data_len_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (load && sel.is_data && !sel.esc_prefix) |=> (rem_q == CNT_W'(MAIN_W - 1)));
  assert_ctrl_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !sel.is_data && !sel.esc_prefix) |=> (rem_q == CNT_W'(ESC_W - 1)));
  assert_tc_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (load && sel.is_data && sel.esc_prefix) |=> (rem_q == CNT_W'(MAX_W - 1)));
endmodule

// File: rtl/ds_line_encoder.sv
module ds_line_encoder (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_en,
  input  logic bit_in,
  output logic dout,
  output logic sout
);
  logic d_q, d_d, s_q, s_d;

  always_comb begin
    d_d = 1'b0;
    s_d = 1'b0;
    if (tx_en) begin
      d_d = bit_in;
      s_d = (bit_in == d_q) ? ~s_q : s_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      d_q <= 1'b0;
      s_q <= 1'b0;
    end else begin
      d_q <= d_d;
      s_q <= s_d;
    end
  end

  assign dout = d_q;
  assign sout = s_q;

  assert_one_edge_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tx_en |=> ($countones({dout ^ $past(dout), sout ^ $past(sout)}) == 1));
  assert_idle_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |=> (!dout && !sout));
endmodule

// File: rtl/ds_char_tx.sv
module ds_char_tx
  import ds_tx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_en,
  input  logic              tc_valid,
  input  logic [BYTE_W-1:0] tc_value,
  output logic              tc_ready,
  input  logic              fct_valid,
  output logic              fct_ready,
  input  logic              req_valid,
  input  logic [1:0]        req_kind,
  input  logic [BYTE_W-1:0] req_byte,
  output logic              req_ready,
  output logic              dout,
  output logic              sout
);
  char_sel_t sel;
  logic      load;
  logic      bit_out;

  ds_char_select u_select (
    .load      (load),
    .tc_valid  (tc_valid),
    .tc_value  (tc_value),
    .fct_valid (fct_valid),
    .req_valid (req_valid),
    .req_kind  (req_kind),
    .req_byte  (req_byte),
    .sel       (sel),
    .tc_ready  (tc_ready),
    .fct_ready (fct_ready),
    .req_ready (req_ready)
  );

  ds_char_serializer u_serializer (
    .clk     (clk),
    .rst_n   (rst_n),
    .tx_en   (tx_en),
    .sel     (sel),
    .load    (load),
    .bit_out (bit_out)
  );

  ds_line_encoder u_encoder (
    .clk    (clk),
    .rst_n  (rst_n),
    .tx_en  (tx_en),
    .bit_in (bit_out),
    .dout   (dout),
    .sout   (sout)
  );

  assert_fct_yields_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fct_ready |-> !tc_valid);
  assert_req_yields_R8: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!tc_valid && !fct_valid));
  assert_single_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({tc_ready, fct_ready, req_ready}));
  assert_no_ready_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |-> !(tc_ready || fct_ready || req_ready));
  assert_ready_once_R9: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |=> !req_ready);
endmodule

// File: tb/ds_char_tx_test.sv
module ds_char_tx_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tx_en = 1'b0;
  logic       tc_valid = 1'b0, fct_valid = 1'b0, req_valid = 1'b0;
  logic [7:0] tc_value = 8'h00, req_byte = 8'h00;
  logic [1:0] req_kind = 2'b00;
  logic       tc_ready, fct_ready, req_ready, dout, sout;

  ds_char_tx uut (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en),
    .tc_valid(tc_valid), .tc_value(tc_value), .tc_ready(tc_ready),
    .fct_valid(fct_valid), .fct_ready(fct_ready),
    .req_valid(req_valid), .req_kind(req_kind), .req_byte(req_byte),
    .req_ready(req_ready), .dout(dout), .sout(sout)
  );

  always #10 clk = ~clk;

  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // kinds: 0 data, 1 EOP, 2 EEP, 3 FCT, 4 time code, 7 malformed
  localparam logic [10:0] VEC [12] = '{
    {3'd0, 8'h00}, {3'd0, 8'hFF}, {3'd0, 8'hA5}, {3'd1, 8'h00},
    {3'd0, 8'h01}, {3'd3, 8'h00}, {3'd2, 8'h00}, {3'd4, 8'h3F},
    {3'd0, 8'h80}, {3'd4, 8'hC0}, {3'd3, 8'h00}, {3'd1, 8'h00}
  };
  localparam logic [7:0] NULL_BITS = 8'b0010_1110;

  // line decoder
  logic       en_seen = 1'b0;
  logic       pd = 1'b0, ps = 1'b0, pv = 1'b0, esc_pend = 1'b0;
  logic       p_bit = 1'b0, f_bit = 1'b0;
  logic [7:0] acc = 8'h00;
  logic [7:0] raw = 8'h00;
  int         raw_n = 0, pos = 0, plen = 0, null_cnt = 0, ev_n = 0;
  logic [2:0] ev_kind [64];
  logic [7:0] ev_val  [64];

  always @(posedge clk) en_seen <= tx_en;

  task automatic push(input logic [2:0] k, input logic [7:0] v);
    if (ev_n < 64) begin
      ev_kind[ev_n] = k;
      ev_val[ev_n]  = v;
      ev_n++;
    end
  endtask

  always @(negedge clk) begin
    if (!en_seen) begin
      pos = 0; pv = 1'b0; esc_pend = 1'b0; pd = 1'b0; ps = 1'b0; raw_n = 0;
    end else begin
      check(((dout ^ pd) + (sout ^ ps)) == 1, "R6 one line changes", {dout, sout}, {pd, ps});
      pd = dout; ps = sout;
      if (raw_n < 8) raw[raw_n] = dout;
      raw_n++;
      if (pos == 0) begin
        p_bit = dout; pos = 1;
      end else if (pos == 1) begin
        f_bit = dout;
        check((p_bit ^ pv ^ f_bit) == 1'b1, "R5 odd parity", p_bit, ~(pv ^ f_bit));
        plen = f_bit ? 2 : 8; acc = 8'h00; pos = 2;
      end else begin
        acc[pos-2] = dout;
        pos++;
        if (pos - 2 == plen) begin
          pv = ^acc; pos = 0;
          if (f_bit) begin
            if (esc_pend) begin
              esc_pend = 1'b0;
              if (acc[1:0] == 2'b00) null_cnt++; else push(3'd7, acc);
            end else if (acc[1:0] == 2'b11) esc_pend = 1'b1;
            else if (acc[1:0] == 2'b00) push(3'd3, 8'h00);
            else if (acc[1:0] == 2'b01) push(3'd1, 8'h00);
            else push(3'd2, 8'h00);
          end else begin
            if (esc_pend) begin push(3'd4, acc); esc_pend = 1'b0; end
            else push(3'd0, acc);
          end
        end
      end
    end
  end

  task automatic send(input logic [2:0] k, input logic [7:0] v);
    bit got;
    got = 1'b0;
    if (k == 3'd4) begin tc_valid = 1'b1; tc_value = v; end
    else if (k == 3'd3) fct_valid = 1'b1;
    else begin
      req_valid = 1'b1; req_byte = v;
      req_kind = (k == 3'd0) ? 2'b00 : ((k == 3'd1) ? 2'b01 : 2'b10);
    end
    for (int w = 0; w < 100 && !got; w++) begin
      #1;
      if ((k == 3'd4 && tc_ready) || (k == 3'd3 && fct_ready) || (k < 3'd3 && req_ready))
        got = 1'b1;
      @(negedge clk);
    end
    check(got, "R9 request accepted", got, 1);
    tc_valid = 1'b0; fct_valid = 1'b0; req_valid = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int mark;
    bit t, f, r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // reset state, disabled
    check(dout == 1'b0 && sout == 1'b0, "R7 lines low after reset", {dout, sout}, 0);
    req_valid = 1'b1; tc_valid = 1'b1; fct_valid = 1'b1;
    #1;
    check({tc_ready, fct_ready, req_ready} == 3'b000, "R7 no ready while disabled",
          {tc_ready, fct_ready, req_ready}, 0);
    @(negedge clk);
    req_valid = 1'b0; tc_valid = 1'b0; fct_valid = 1'b0;

    // idle fill from reset
    tx_en = 1'b1;
    repeat (20) @(negedge clk);
    check(raw == NULL_BITS, "R3 first NULL bit pattern", raw, NULL_BITS);
    check(null_cnt >= 2, "R3 NULL fill while idle", null_cnt, 2);
    check(ev_n == 0, "R3 nothing but NULL when idle", ev_n, 0);

    // vector table
    for (int i = 0; i < 12; i++) send(VEC[i][10:8], VEC[i][7:0]);
    repeat (40) @(negedge clk);
    check(ev_n == 12, "R1 R2 R4 character count", ev_n, 12);
    for (int i = 0; i < 12; i++) begin
      if (VEC[i][10:8] == 3'd0)
        check(ev_kind[i] == 3'd0 && ev_val[i] == VEC[i][7:0], "R1 data character",
              {ev_kind[i], ev_val[i]}, VEC[i]);
      else if (VEC[i][10:8] == 3'd4)
        check(ev_kind[i] == 3'd4 && ev_val[i] == VEC[i][7:0], "R4 time code",
              {ev_kind[i], ev_val[i]}, VEC[i]);
      else
        check(ev_kind[i] == VEC[i][10:8], "R2 control character", ev_kind[i], VEC[i][10:8]);
    end

    // disable, then offer all three at once
    tx_en = 1'b0;
    @(negedge clk); @(negedge clk);
    check(dout == 1'b0 && sout == 1'b0, "R7 lines low when disabled", {dout, sout}, 0);
    tc_valid = 1'b1; tc_value = 8'h55; fct_valid = 1'b1;
    req_valid = 1'b1; req_kind = 2'b00; req_byte = 8'h66;
    mark = ev_n;
    tx_en = 1'b1;
    for (int c = 0; c < 100; c++) begin
      #1;
      t = tc_ready; f = fct_ready; r = req_ready;
      check((t + f + r) <= 1, "R9 one ready at a time", t + f + r, 1);
      @(negedge clk);
      if (t) tc_valid = 1'b0;
      if (f) fct_valid = 1'b0;
      if (r) req_valid = 1'b0;
      if (!tc_valid && !fct_valid && !req_valid) break;
    end
    repeat (30) @(negedge clk);
    check(ev_kind[mark] == 3'd4 && ev_val[mark] == 8'h55, "R8 time code first",
          {ev_kind[mark], ev_val[mark]}, {3'd4, 8'h55});
    check(ev_kind[mark+1] == 3'd3, "R8 FCT second", ev_kind[mark+1], 3);
    check(ev_kind[mark+2] == 3'd0 && ev_val[mark+2] == 8'h66, "R8 data last",
          {ev_kind[mark+2], ev_val[mark+2]}, {3'd0, 8'h66});

    // disable in the middle of a character, then restart
    send(3'd0, 8'hC3);
    repeat (2) @(negedge clk);
    tx_en = 1'b0;
    @(negedge clk);
    check(dout == 1'b0 && sout == 1'b0, "R7 lines drop mid character", {dout, sout}, 0);
    mark = ev_n;
    repeat (2) @(negedge clk);
    tx_en = 1'b1;
    repeat (12) @(negedge clk);
    check(raw == NULL_BITS, "R7 R5 chain restarts after disable", raw, NULL_BITS);
    check(ev_n == mark, "R7 cut character not completed", ev_n, mark);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule